// File: doc/BRIEF.md
# Predicated gather prefetch address generator

This block turns one gather-prefetch command into a stream of prefetch requests. A command carries a 64-bit scalar base, a packed vector of index elements, a byte-granular predicate mask, an element/offset mode, an extend flag and a 4-bit hint code. For every element whose predicate is set, the block forms the address `base + (offset << 2)`. The index therefore counts 4-byte words. It sends one request downstream for each such element. Each request carries its address, its element number and the decoded hint fields.

Commands arrive over a valid/ready handshake. The block takes a command only while it is idle. It holds `cmd_ready` low from the cycle after acceptance until the last request has been taken. Requests leave over a second valid/ready handshake, at most one per cycle, in ascending element order. The downstream side may stall by holding `req_ready` low. A stalled request stays unchanged until it is taken. A single-cycle `done` pulse marks the end of each command.

The vector width `VLEN` is a parameter. It must be a power of two and at least 64. The predicate is `VLEN/8` bits wide.

Top module: `gpf_addr_gen`

## Requirements
- R1: The request address is the command base plus the extended offset multiplied by 4. The sum wraps modulo 2^64, with no overflow indication.
- R2: Mode 0 uses 32-bit elements with 32-bit offsets. Element e is taken from `cmd_index[32e+31:32e]`. It is zero-extended when `cmd_sext` is 0 and sign-extended when it is 1.
- R3: Mode 1 uses 64-bit elements with 32-bit offsets. Only bits `[64e+31:64e]` of element e are used, and bits `[64e+63:64e+32]` are ignored. Those 32 bits are zero-extended when `cmd_sext` is 0 and sign-extended when it is 1.
- R4: Modes 2 and 3 use 64-bit elements with full 64-bit unsigned offsets taken from `cmd_index[64e+63:64e]`. `cmd_sext` has no effect in these modes.
- R5: Element e is active only when the predicate bit at its lowest byte is set. That bit is `cmd_pred[4e]` in mode 0 and `cmd_pred[8e]` in the other modes. All other predicate bits are ignored. The number of requests equals the number of active elements.
- R6: Requests for a command leave in strictly ascending element order. `req_elem` gives the element number.
- R7: Every request carries the decoded hint. `req_store` is hint bit 3 (0 means load, 1 means store). `req_level` is hint bits 2:1. `req_stream` is hint bit 0, and 1 marks a non-temporal access.
- R8: While `req_valid` is 1 and `req_ready` is 0, `req_valid`, `req_addr`, `req_elem` and the hint fields stay unchanged. A request is consumed in the cycle where both are 1.
- R9: `cmd_ready` is 1 while idle. It is 0 in every cycle in which a request is pending.
- R10: `done` is 1 for the cycle after the last active element's request is accepted. For a command with no active element, `done` is 1 in the cycle after the command is accepted, and no request is issued.
- R11: During and after reset, `req_valid` and `done` are 0 and `cmd_ready` is 1. A reset in the middle of a command abandons it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can take a command (idle) |
| cmd_base | input | 64 | Scalar base address |
| cmd_index | input | VLEN | Packed index elements |
| cmd_pred | input | VLEN/8 | Predicate, one bit per vector byte |
| cmd_mode | input | 2 | 0: 32/32, 1: 64-bit element with 32-bit offset, 2 or 3: 64/64 |
| cmd_sext | input | 1 | Sign-extend 32-bit offsets when 1 |
| cmd_hint | input | 4 | Hint code: bit 3 store, bits 2:1 level, bit 0 streaming |
| req_valid | output | 1 | Prefetch request pending |
| req_ready | input | 1 | Downstream takes the request |
| req_addr | output | 64 | Prefetch address |
| req_elem | output | log2(VLEN/32) | Element number of the request |
| req_store | output | 1 | Store intent |
| req_level | output | 2 | Target cache level |
| req_stream | output | 1 | Non-temporal access |
| done | output | 1 | Command finished pulse |

## Verification
Assertions watch the handshake rules on every cycle. They check that a stalled request holds still, that commands are refused while a request is pending, that element numbers rise within a command, and that `done` never coincides with a pending request. Only the bench scenarios can show the address arithmetic itself. That covers the extension choice per mode, the ignored upper halves and extend flag, the wrap past 2^64, and which predicate bits select elements. The bench also shows the exact request count, the cycle of the `done` pulse and recovery from a reset in mid-command.

// File: rtl/gpf_pkg.sv
package gpf_pkg;

  typedef enum logic [1:0] {
    GPF_W32_O32  = 2'd0,
    GPF_W64_O32  = 2'd1,
    GPF_W64_O64  = 2'd2,
    GPF_W64_O64B = 2'd3
  } gpf_mode_e;

  typedef struct packed {
    logic       store;
    logic [1:0] level;
    logic       stream;
  } gpf_hint_t;

  function automatic gpf_hint_t gpf_split_hint(input logic [3:0] code);
    gpf_hint_t h;
    h.store  = code[3];
    h.level  = code[2:1];
    h.stream = code[0];
    return h;
  endfunction

endpackage

// File: rtl/gpf_lane_mask.sv
module gpf_lane_mask
  import gpf_pkg::*;
#(
  parameter int VLEN = 256,
  localparam int NE   = VLEN / 32,
  localparam int NE64 = VLEN / 64,
  localparam int PW   = VLEN / 8
) (
  input  logic [PW-1:0] pred,
  input  gpf_mode_e     mode,
  output logic [NE-1:0] active
);

  logic narrow;
  assign narrow = (mode == GPF_W32_O32);

  for (genvar e = 0; e < NE; e++) begin : g_lane
    if (e < NE64) begin : g_both
      assign active[e] = narrow ? pred[4*e] : pred[8*e];
    end else begin : g_narrow_only
      assign active[e] = narrow ? pred[4*e] : 1'b0;
    end
  end

endmodule

// File: rtl/gpf_pick_first.sv
module gpf_pick_first #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  mask,
  output logic          any,
  output logic [IW-1:0] idx
);

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end

endmodule

// File: rtl/gpf_addr_calc.sv
module gpf_addr_calc
  import gpf_pkg::*;
#(
  parameter int VLEN = 256,
  localparam int NE   = VLEN / 32,
  localparam int NE64 = VLEN / 64,
  localparam int IW   = $clog2(NE)
) (
  input  logic [63:0]     base,
  input  logic [VLEN-1:0] vec,
  input  logic [IW-1:0]   idx,
  input  gpf_mode_e       mode,
  input  logic            sext,
  output logic [63:0]     addr
);

  logic [31:0] word32 [NE];
  logic [63:0] word64 [NE];

  for (genvar e = 0; e < NE; e++) begin : g_w32
    assign word32[e] = vec[32*e +: 32];
  end

  for (genvar e = 0; e < NE; e++) begin : g_w64
    if (e < NE64) begin : g_real
      assign word64[e] = vec[64*e +: 64];
    end else begin : g_pad
      assign word64[e] = '0;
    end
  end

  logic [31:0] low;
  logic [63:0] offset;

  always_comb begin
    low = (mode == GPF_W32_O32) ? word32[idx] : word64[idx][31:0];
    unique case (mode)
      GPF_W32_O32, GPF_W64_O32: offset = sext ? {{32{low[31]}}, low} : {32'h0, low};
      default:                  offset = word64[idx];
    endcase
  end

  assign addr = base + (offset << 2);

endmodule

// File: rtl/gpf_addr_gen.sv
module gpf_addr_gen
  import gpf_pkg::*;
#(
  parameter int VLEN = 256,
  localparam int IW  = $clog2(VLEN / 32)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [63:0]       cmd_base,
  input  logic [VLEN-1:0]   cmd_index,
  input  logic [VLEN/8-1:0] cmd_pred,
  input  logic [1:0]        cmd_mode,
  input  logic              cmd_sext,
  input  logic [3:0]        cmd_hint,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [63:0]       req_addr,
  output logic [IW-1:0]     req_elem,
  output logic              req_store,
  output logic [1:0]        req_level,
  output logic              req_stream,
  output logic              done
);

  localparam int NE = VLEN / 32;

  logic            busy_q;
  logic            done_q;
  logic [NE-1:0]   rem_q;
  logic [63:0]     base_q;
  logic [VLEN-1:0] vec_q;
  gpf_mode_e       mode_q;
  logic            sext_q;
  gpf_hint_t       hint_q;

  logic [NE-1:0]   new_mask;
  logic            new_any;
  logic [IW-1:0]   new_first;
  logic            pick_any;
  logic [IW-1:0]   pick_idx;
  logic [NE-1:0]   rem_clr;
  logic            accept;
  logic            fire;

  gpf_lane_mask #(.VLEN(VLEN)) u_mask (
    .pred   (cmd_pred),
    .mode   (gpf_mode_e'(cmd_mode)),
    .active (new_mask)
  );

  gpf_pick_first #(.N(NE)) u_new_any (
    .mask (new_mask),
    .any  (new_any),
    .idx  (new_first)
  );

  gpf_pick_first #(.N(NE)) u_pick (
    .mask (rem_q),
    .any  (pick_any),
    .idx  (pick_idx)
  );

  gpf_addr_calc #(.VLEN(VLEN)) u_addr (
    .base (base_q),
    .vec  (vec_q),
    .idx  (pick_idx),
    .mode (mode_q),
    .sext (sext_q),
    .addr (req_addr)
  );

  assign cmd_ready = !busy_q;
  assign accept    = cmd_valid && cmd_ready;
  assign req_valid = busy_q && pick_any;
  assign fire      = req_valid && req_ready;
  assign rem_clr   = rem_q & ~(NE'(1) << pick_idx);

  assign req_elem   = pick_idx;
  assign req_store  = hint_q.store;
  assign req_level  = hint_q.level;
  assign req_stream = hint_q.stream;
  assign done       = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rem_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        rem_q  <= new_mask;
        busy_q <= new_any;
        done_q <= !new_any;
      end else if (fire) begin
        rem_q <= rem_clr;
        if (rem_clr == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  // Operands are captured only when at least one element will issue.
  always_ff @(posedge clk) begin
    if (accept && new_any) begin
      base_q <= cmd_base;
      vec_q  <= cmd_index;
      mode_q <= gpf_mode_e'(cmd_mode);
      sext_q <= cmd_sext;
      hint_q <= gpf_split_hint(cmd_hint);
    end
  end

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_elem)
                                   && $stable(req_level) && $stable(req_store) && $stable(req_stream)));

  // R9
  busy_blocks_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !cmd_ready);

  // R6
  ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_valid || (req_elem > $past(req_elem))));

  // R10
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid);

  // R10
  empty_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !new_any) |=> (done && !req_valid));

  // R5
  first_elem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && new_any) |=> (req_valid && req_elem == $past(new_first)));

endmodule

// File: tb/gpf_addr_gen_tb_top.sv
`timescale 1ns/1ps
module gpf_addr_gen_tb_top;

  localparam int VLEN = 256;

  typedef struct packed {
    logic [1:0]   mode;
    logic         sext;
    logic [3:0]   hint;
    logic [31:0]  pred;
    logic [63:0]  base;
    logic [255:0] vec;
    logic         stall;
    logic [3:0]   exp_n;
  } ent_t;

  localparam logic [255:0] VA =
    256'hDEADBEEF_12345678_FFFFFFF0_00000010_7FFFFFFF_80000000_FFFFFFFF_00000001;
  localparam logic [255:0] VB =
    256'h80000000_00000000_FFFF0000_80000001_12340000_00000003_AAAA5555_FFFFFFFE;

  localparam int NT = 11;
  localparam ent_t TBL [NT] = '{
    '{2'd0, 1'b0, 4'h0, 32'hFFFFFFFF, 64'h0000_0000_0000_1000, VA, 1'b0, 4'd8},
    '{2'd0, 1'b1, 4'h9, 32'h01010101, 64'h0000_0000_0000_1000, VA, 1'b0, 4'd4},
    '{2'd1, 1'b1, 4'h6, 32'h01010101, 64'h0000_0001_0000_0000, VB, 1'b0, 4'd4},
    '{2'd1, 1'b0, 4'hB, 32'h00010001, 64'h0000_0001_0000_0000, VB, 1'b0, 4'd2},
    '{2'd2, 1'b1, 4'h2, 32'hFFFFFFFF, 64'hFFFF_FFFF_FFFF_FF00, VB, 1'b0, 4'd4},
    '{2'd0, 1'b0, 4'hF, 32'h0000EE10, 64'h0000_0000_0000_0040, VA, 1'b0, 4'd1},
    '{2'd2, 1'b0, 4'h5, 32'h00010010, 64'h0000_0000_0000_0000, VB, 1'b0, 4'd1},
    '{2'd0, 1'b0, 4'h0, 32'h00000000, 64'h0000_0000_0000_0000, VA, 1'b0, 4'd0},
    '{2'd1, 1'b1, 4'h8, 32'h00001010, 64'h0000_0000_0000_0000, VB, 1'b0, 4'd0},
    '{2'd0, 1'b1, 4'hC, 32'hFFFFFFFF, 64'hFFFF_FFFF_FFFF_FFF0, VA, 1'b1, 4'd8},
    '{2'd3, 1'b1, 4'h3, 32'h01000001, 64'h0000_0000_0000_0100, VB, 1'b0, 4'd2}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_valid = 1'b0;
  logic              cmd_ready;
  logic [63:0]       cmd_base = '0;
  logic [VLEN-1:0]   cmd_index = '0;
  logic [VLEN/8-1:0] cmd_pred = '0;
  logic [1:0]        cmd_mode = '0;
  logic              cmd_sext = 1'b0;
  logic [3:0]        cmd_hint = '0;
  logic              req_valid;
  logic              req_ready = 1'b1;
  logic [63:0]       req_addr;
  logic [2:0]        req_elem;
  logic              req_store;
  logic [1:0]        req_level;
  logic              req_stream;
  logic              done;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;

  gpf_addr_gen #(.VLEN(VLEN)) dut_i (
    .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_base, .cmd_index, .cmd_pred,
    .cmd_mode, .cmd_sext, .cmd_hint, .req_valid, .req_ready, .req_addr,
    .req_elem, .req_store, .req_level, .req_stream, .done
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_checks - n_fails, n_checks);
  endtask

  task automatic run_entry(input int ti);
    ent_t t;
    logic [63:0] ea [8];
    int          ee [8];
    int          n;
    int          got;
    int          cyc;
    bit          held;
    logic [63:0] held_addr;
    string       atag;
    t = TBL[ti];
    n = 0;
    for (int e = 0; e < 8; e++) begin
      logic act;
      logic [31:0] w;
      logic [63:0] off;
      if (t.mode == 2'd0) begin
        act = t.pred[4*e];
        w   = t.vec[32*e +: 32];
        off = t.sext ? {{32{w[31]}}, w} : {32'h0, w};
      end else if (e < 4) begin
        act = t.pred[8*e];
        w   = t.vec[64*e +: 32];
        if (t.mode == 2'd1) off = t.sext ? {{32{w[31]}}, w} : {32'h0, w};
        else                off = t.vec[64*e +: 64];
      end else begin
        act = 1'b0;
        off = '0;
      end
      if (act) begin
        ea[n] = t.base + (off << 2);
        ee[n] = e;
        n++;
      end
    end
    atag = (t.mode == 2'd0) ? "R2 R1" : (t.mode == 2'd1) ? "R3 R1" : "R4 R1";

    @(negedge clk);
    chk(cmd_ready == 1'b1, "R9 idle ready", 64'(cmd_ready), 64'd1);
    cmd_valid = 1'b1;
    cmd_base  = t.base;
    cmd_index = t.vec;
    cmd_pred  = t.pred;
    cmd_mode  = t.mode;
    cmd_sext  = t.sext;
    cmd_hint  = t.hint;
    req_ready = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    got  = 0;
    cyc  = 0;
    held = 1'b0;
    held_addr = '0;
    while (got < int'(t.exp_n) && cyc < 100) begin
      if (held) chk(req_valid && req_addr == held_addr, "R8 stalled request held", req_addr, held_addr);
      held = 1'b0;
      chk(!done && cmd_ready == 1'b0, "R9 busy refuses command", {done, cmd_ready}, 64'd0);
      if (req_valid && req_ready) begin
        if (got < n) begin
          chk(req_addr == ea[got], atag, req_addr, ea[got]);
          chk(int'(req_elem) == ee[got], "R6 element order", 64'(req_elem), 64'(ee[got]));
        end
        chk({req_store, req_level, req_stream} == t.hint, "R7 hint fields",
            64'({req_store, req_level, req_stream}), 64'(t.hint));
        got++;
      end else if (req_valid) begin
        held = 1'b1;
        held_addr = req_addr;
      end
      cyc++;
      @(negedge clk);
      req_ready = t.stall ? ((cyc % 3) != 1) : 1'b1;
    end
    chk(got == int'(t.exp_n), "R5 request count", 64'(got), 64'(t.exp_n));
    chk(done && !req_valid, "R10 done after last request", {done, req_valid}, 64'h2);
    chk(cmd_ready == 1'b1, "R9 ready after finish", 64'(cmd_ready), 64'd1);
    @(negedge clk);
    chk(!done, "R10 done is single cycle", 64'(done), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    // R11: reset state
    repeat (2) @(negedge clk);
    chk(!req_valid && !done && cmd_ready, "R11 reset outputs",
        {req_valid, done, cmd_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req_valid && !done && cmd_ready, "R11 idle after reset",
        {req_valid, done, cmd_ready}, 64'd1);

    for (int i = 0; i < NT; i++) run_entry(i);

    // R11: reset in the middle of a stalled command
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_base  = TBL[0].base;
    cmd_index = TBL[0].vec;
    cmd_pred  = TBL[0].pred;
    cmd_mode  = TBL[0].mode;
    cmd_sext  = 1'b0;
    cmd_hint  = 4'h0;
    req_ready = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(req_valid == 1'b1, "R11 command pending before reset", 64'(req_valid), 64'd1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!req_valid && !done && cmd_ready, "R11 mid-command reset clears",
        {req_valid, done, cmd_ready}, 64'd1);
    rst_n = 1'b1;
    req_ready = 1'b1;
    @(negedge clk);
    run_entry(3);

    summary();
    $finish;
  end

endmodule